// File: doc/BRIEF.md
# MSI Snooping Coherence Controller

This block keeps a small direct-mapped cache coherent with its peers on a shared bus using a write-invalidate protocol. Every line carries one of three states: Invalid (unusable), Shared (readable only) or Modified (writable and possibly newer than memory). A processor-side state machine serves loads and stores. It issues read misses, write misses and write-backs on the bus. A snoop-side path watches read-miss and write-miss transactions from other caches. It demotes or invalidates its own lines and supplies dirty data when a peer needs it.

The processor holds its request stable until `cpu_ready` is seen. Hits complete in the cycle of the request. A miss raises `bus_req` and keeps it raised until the bus grants the controller and reports completion. While the controller owns the bus, its transaction behaves as one indivisible step. A snoop and a processor request in the same cycle both need the line array, and the snoop wins.

Top module: `msi_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid: a snooped transaction returns no data (`snp_wb`=0) and the first load of any address issues a read miss.
- R2: A load that hits a Shared or Modified line, and a store that hits a Modified line, complete in the request cycle with `bus_req` low; a load returns the cached word.
- R3: A load to a line that is not present issues `bus_cmd`=1 (read miss) for the full request address. On completion it returns `bus_rdata` and leaves the line Shared.
- R4: A store to a line that is not present issues `bus_cmd`=2 (write miss). On completion it stores the word and leaves the line Modified, so a later store hits without bus traffic.
- R5: A store that hits a Shared line issues `bus_cmd`=2 for that address and then leaves the line Modified.
- R6: A miss whose index holds a different block in Modified first issues `bus_cmd`=3 (write-back) with the victim's address (stored tag above index bits) and data, then the new miss. A different block in Shared is replaced with no write-back.
- R7: A snooped read miss (`snp_cmd`=1) that hits a Modified line asserts `snp_wb` with the line's data in the same cycle, and the line drops to Shared.
- R8: A snooped write miss (`snp_cmd`=2) that hits a Shared line invalidates it without asserting `snp_wb`.
- R9: A snooped write miss that hits a Modified line asserts `snp_wb` with the line's data and invalidates the line.
- R10: A snooped read miss to a Shared line, and any snoop whose tag differs from the stored tag, leave the line unchanged and keep `snp_wb` low.
- R11: In a cycle with `snp_valid` high the processor request is not served: `cpu_ready` stays low and the request is served in a later cycle.
- R12: Once granted, `bus_req`, `bus_cmd` and `bus_addr` stay unchanged until `bus_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Store data |
| cpu_ready | output | 1 | Request completes this cycle |
| cpu_rdata | output | DATA_W | Load data, valid with `cpu_ready` |
| bus_req | output | 1 | Controller wants or holds the bus |
| bus_cmd | output | 2 | 1 read miss, 2 write miss, 3 write-back |
| bus_addr | output | ADDR_W | Address of the bus transaction |
| bus_wdata | output | DATA_W | Write-back data |
| bus_gnt | input | 1 | Bus granted to this controller |
| bus_done | input | 1 | Granted transaction completes this cycle |
| bus_rdata | input | DATA_W | Fill data for a read miss |
| snp_valid | input | 1 | A peer transaction is on the bus |
| snp_cmd | input | 2 | 1 read miss, 2 write miss |
| snp_addr | input | ADDR_W | Address of the peer transaction |
| snp_wb | output | 1 | Supplying dirty data; memory access aborted |
| snp_data | output | DATA_W | Data supplied on `snp_wb` |

## Verification
The bench builds the controller with 8 lines and an 8-bit word address, so the index is address bits 2:0 and a 5-bit tag lies above it. Two addresses such as 0x11 and 0x19 then collide on one line. This makes dirty and clean conflict evictions, snoops with a mismatched tag, and every state transition reachable within a handful of accesses. A bus model in the bench delays the grant and the completion by one cycle each, so the holding of the bus request and its fields can be observed across cycles.

// File: rtl/msi_snoop_ctrl.sv
module msi_snoop_ctrl #(
  parameter int LINES  = 8,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              bus_req,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_gnt,
  input  logic              bus_done,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_wb,
  output logic [DATA_W-1:0] snp_data
);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam logic [1:0] ST_I = 2'd0, ST_S = 2'd1, ST_M = 2'd2;
  localparam logic [1:0] CMD_RD = 2'd1, CMD_WR = 2'd2, CMD_WB = 2'd3;

  typedef enum logic [1:0] {P_IDLE, P_WB, P_MISS} pst_t;
  pst_t pst;

  logic [LINES-1:0][1:0] line_st;
  logic [TAG_W-1:0]      line_tag [LINES];
  logic [DATA_W-1:0]     line_dat [LINES];

  logic [IDX_W-1:0] cpu_idx, snp_idx;
  logic [TAG_W-1:0] cpu_tag, snp_tag;
  logic [1:0]       cur_st, snp_st;
  logic tag_eq, present, rd_hit, wr_hit, serve, victim_dirty, fill_done, snp_hit;

  assign cpu_idx = cpu_addr[IDX_W-1:0];
  assign cpu_tag = cpu_addr[ADDR_W-1:IDX_W];
  assign cur_st  = line_st[cpu_idx];
  assign tag_eq  = line_tag[cpu_idx] == cpu_tag;
  assign present = (cur_st != ST_I) && tag_eq;
  assign rd_hit  = !cpu_we && present;
  assign wr_hit  = cpu_we && present && (cur_st == ST_M);
  assign serve   = cpu_req && !snp_valid && (pst == P_IDLE);
  assign victim_dirty = (cur_st == ST_M) && !tag_eq;
  assign fill_done    = (pst == P_MISS) && bus_gnt && bus_done;

  assign cpu_ready = (serve && (rd_hit || wr_hit)) || fill_done;
  assign cpu_rdata = fill_done ? bus_rdata : line_dat[cpu_idx];

  assign bus_req   = ((pst == P_WB) && victim_dirty) || (pst == P_MISS);
  assign bus_cmd   = (pst == P_WB) ? CMD_WB : (cpu_we ? CMD_WR : CMD_RD);
  assign bus_addr  = (pst == P_WB) ? {line_tag[cpu_idx], cpu_idx} : cpu_addr;
  assign bus_wdata = line_dat[cpu_idx];

  assign snp_idx  = snp_addr[IDX_W-1:0];
  assign snp_tag  = snp_addr[ADDR_W-1:IDX_W];
  assign snp_st   = line_st[snp_idx];
  assign snp_hit  = snp_valid && (snp_st != ST_I) && (line_tag[snp_idx] == snp_tag);
  assign snp_wb   = snp_hit && (snp_st == ST_M) && (snp_cmd == CMD_RD || snp_cmd == CMD_WR);
  assign snp_data = line_dat[snp_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pst <= P_IDLE;
    end else begin
      case (pst)
        P_IDLE: if (serve && !(rd_hit || wr_hit)) pst <= victim_dirty ? P_WB : P_MISS;
        P_WB:   if (!victim_dirty || (bus_gnt && bus_done)) pst <= P_MISS;
        P_MISS: if (fill_done) pst <= P_IDLE;
        default: pst <= P_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_st <= '0;
    end else begin
      if (fill_done) line_st[cpu_idx] <= cpu_we ? ST_M : ST_S;
      if (snp_hit && snp_cmd == CMD_RD && snp_st == ST_M) line_st[snp_idx] <= ST_S;
      if (snp_hit && snp_cmd == CMD_WR) line_st[snp_idx] <= ST_I;
    end
  end

  always_ff @(posedge clk) begin
    if (serve && wr_hit) line_dat[cpu_idx] <= cpu_wdata;
    if (fill_done) begin
      line_tag[cpu_idx] <= cpu_tag;
      line_dat[cpu_idx] <= cpu_we ? cpu_wdata : bus_rdata;
    end
  end
endmodule

// File: rtl/msi_snoop_chk.sv
module msi_snoop_chk #(
  parameter int LINES  = 8,
  parameter int ADDR_W = 8
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      cpu_ready,
  input logic                      bus_req,
  input logic [1:0]                bus_cmd,
  input logic [ADDR_W-1:0]         bus_addr,
  input logic                      bus_gnt,
  input logic                      bus_done,
  input logic                      snp_valid,
  input logic [1:0]                snp_cmd,
  input logic                      snp_wb,
  input logic                      snp_hit,
  input logic [$clog2(LINES)-1:0]  snp_idx,
  input logic [LINES-1:0][1:0]     line_st
);
  AST_BUS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_gnt && !bus_done |=> bus_req && $stable(bus_cmd) && $stable(bus_addr)); // R12
  AST_SNOOP_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid && !bus_done |-> !cpu_ready); // R11
  AST_HIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready && !bus_done |-> !bus_req); // R2
  AST_WB_LEAVES_M: assert property (@(posedge clk) disable iff (!rst_n)
    snp_wb && !bus_done |=> line_st[$past(snp_idx)] != 2'd2); // R7
  AST_SNP_INVALIDATE: assert property (@(posedge clk) disable iff (!rst_n)
    snp_hit && snp_cmd == 2'd2 && !bus_done |=> line_st[$past(snp_idx)] == 2'd0); // R8
  AST_NO_WB_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid && line_st[snp_idx] != 2'd2 |-> !snp_wb); // R10
endmodule

bind msi_snoop_ctrl msi_snoop_chk #(.LINES(LINES), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/test_msi_snoop_ctrl.sv
module test_msi_snoop_ctrl;
  logic clk = 0, rst_n = 0;
  logic cpu_req = 0, cpu_we = 0;
  logic [7:0] cpu_addr = '0;
  logic [31:0] cpu_wdata = '0, cpu_rdata;
  logic cpu_ready, bus_req, snp_wb;
  logic [1:0] bus_cmd;
  logic [7:0] bus_addr;
  logic [31:0] bus_wdata, snp_data;
  logic bus_gnt = 0, bus_done = 0, snp_valid = 0;
  logic [31:0] bus_rdata = '0;
  logic [1:0] snp_cmd = '0;
  logic [7:0] snp_addr = '0;

  msi_snoop_ctrl #(.LINES(8), .ADDR_W(8), .DATA_W(32)) i_msi_snoop_ctrl (.*);

  always #10 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit fin = 0;
  logic [31:0] mem [256];
  logic [1:0]  lg_cmd [4];
  logic [7:0]  lg_addr [4];
  logic [31:0] lg_dat [4];
  int nlog;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cpu_op(input logic we, input logic [7:0] a, input logic [31:0] wd,
                        output logic [31:0] rd);
    int ph;
    @(negedge clk);
    cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = wd; nlog = 0; ph = 0;
    forever begin
      #2;
      if (bus_req) begin
        if (ph == 0) begin
          if (nlog < 4) begin
            lg_cmd[nlog] = bus_cmd; lg_addr[nlog] = bus_addr; lg_dat[nlog] = bus_wdata;
          end
          nlog++;
        end else begin
          check("R12 cmd held", {30'd0, bus_cmd}, {30'd0, lg_cmd[nlog-1]});
          check("R12 addr held", {24'd0, bus_addr}, {24'd0, lg_addr[nlog-1]});
        end
        bus_gnt = (ph >= 1); bus_done = (ph >= 2); bus_rdata = mem[bus_addr];
        ph++;
      end
      #1;
      if (bus_done && bus_cmd == 2'd3) mem[bus_addr] = bus_wdata;
      if (bus_done) ph = 0;
      if (cpu_ready) begin
        rd = cpu_rdata;
        break;
      end
      @(negedge clk);
      bus_gnt = 0; bus_done = 0;
    end
    @(negedge clk);
    cpu_req = 0; bus_gnt = 0; bus_done = 0;
  endtask

  task automatic snoop(input logic [1:0] c, input logic [7:0] a,
                       output logic wb, output logic [31:0] d);
    @(negedge clk);
    snp_valid = 1; snp_cmd = c; snp_addr = a;
    #2;
    wb = snp_wb; d = snp_data;
    if (wb) mem[a] = d;
    @(negedge clk);
    snp_valid = 0;
  endtask

  task automatic t_reset;
    logic wb; logic [31:0] d, rd;
    check("R1 bus_req idle", {31'd0, bus_req}, 0);
    check("R1 cpu_ready idle", {31'd0, cpu_ready}, 0);
    snoop(2'd1, 8'h11, wb, d);
    check("R1 snoop after reset no data", {31'd0, wb}, 0);
    cpu_op(0, 8'h11, 0, rd);
    check("R1 first load misses", nlog, 1);
    check("R3 read miss cmd", {30'd0, lg_cmd[0]}, 1);
    check("R3 read miss addr", {24'd0, lg_addr[0]}, 32'h11);
    check("R3 fill data", rd, mem[8'h11]);
  endtask

  task automatic t_hits_and_upgrade;
    logic [31:0] rd;
    cpu_op(0, 8'h11, 0, rd);
    check("R2 shared read hit no bus", nlog, 0);
    check("R2 shared read hit data", rd, mem[8'h11]);
    cpu_op(1, 8'h11, 32'h1111_AAAA, rd);
    check("R5 upgrade one bus op", nlog, 1);
    check("R5 upgrade is write miss", {30'd0, lg_cmd[0]}, 2);
    check("R5 upgrade addr", {24'd0, lg_addr[0]}, 32'h11);
    cpu_op(0, 8'h11, 0, rd);
    check("R2 modified read hit no bus", nlog, 0);
    check("R2 modified read hit data", rd, 32'h1111_AAAA);
    cpu_op(1, 8'h11, 32'h2222_BBBB, rd);
    check("R2 modified write hit no bus", nlog, 0);
  endtask

  task automatic t_write_miss;
    logic [31:0] rd;
    cpu_op(1, 8'h22, 32'h3333_CCCC, rd);
    check("R4 write miss one op", nlog, 1);
    check("R4 write miss cmd", {30'd0, lg_cmd[0]}, 2);
    check("R4 write miss addr", {24'd0, lg_addr[0]}, 32'h22);
    cpu_op(1, 8'h22, 32'h3434_CDCD, rd);
    check("R4 later store hits", nlog, 0);
    cpu_op(0, 8'h22, 0, rd);
    check("R4 stored word", rd, 32'h3434_CDCD);
  endtask

  task automatic t_conflict;
    logic [31:0] rd;
    cpu_op(0, 8'h19, 0, rd);
    check("R6 dirty victim two ops", nlog, 2);
    check("R6 write-back first", {30'd0, lg_cmd[0]}, 3);
    check("R6 write-back addr", {24'd0, lg_addr[0]}, 32'h11);
    check("R6 write-back data", lg_dat[0], 32'h2222_BBBB);
    check("R6 then read miss", {30'd0, lg_cmd[1]}, 1);
    check("R6 read miss addr", {24'd0, lg_addr[1]}, 32'h19);
    check("R6 new block data", rd, mem[8'h19]);
    cpu_op(0, 8'h11, 0, rd);
    check("R6 clean victim no write-back", nlog, 1);
    check("R6 clean victim read miss", {30'd0, lg_cmd[0]}, 1);
    check("R6 written-back data returns", rd, 32'h2222_BBBB);
  endtask

  task automatic t_snoops;
    logic wb; logic [31:0] d, rd;
    snoop(2'd1, 8'h22, wb, d);
    check("R7 snoop read on M supplies", {31'd0, wb}, 1);
    check("R7 supplied data", d, 32'h3434_CDCD);
    cpu_op(1, 8'h22, 32'h4444_DDDD, rd);
    check("R7 line now Shared: store upgrades", nlog, 1);
    check("R7 upgrade cmd", {30'd0, lg_cmd[0]}, 2);
    snoop(2'd2, 8'h22, wb, d);
    check("R9 snoop write on M supplies", {31'd0, wb}, 1);
    check("R9 supplied data", d, 32'h4444_DDDD);
    cpu_op(0, 8'h22, 0, rd);
    check("R9 line invalid: load misses", nlog, 1);
    check("R9 refetched data", rd, 32'h4444_DDDD);
    snoop(2'd2, 8'h11, wb, d);
    check("R8 snoop write on S no data", {31'd0, wb}, 0);
    cpu_op(0, 8'h11, 0, rd);
    check("R8 line invalid: load misses", nlog, 1);
    snoop(2'd1, 8'h11, wb, d);
    check("R10 snoop read on S no data", {31'd0, wb}, 0);
    snoop(2'd1, 8'h09, wb, d);
    check("R10 read tag mismatch no data", {31'd0, wb}, 0);
    snoop(2'd2, 8'h31, wb, d);
    check("R10 write tag mismatch no data", {31'd0, wb}, 0);
    cpu_op(0, 8'h11, 0, rd);
    check("R10 line kept: load hits", nlog, 0);
    check("R10 line kept data", rd, 32'h2222_BBBB);
  endtask

  task automatic t_stall;
    @(negedge clk);
    cpu_req = 1; cpu_we = 0; cpu_addr = 8'h11;
    snp_valid = 1; snp_cmd = 2'd1; snp_addr = 8'h40;
    #2;
    check("R11 stalled during snoop", {31'd0, cpu_ready}, 0);
    check("R11 no bus during stall", {31'd0, bus_req}, 0);
    @(negedge clk);
    snp_valid = 0;
    #2;
    check("R11 served after snoop", {31'd0, cpu_ready}, 1);
    check("R11 served data", cpu_rdata, 32'h2222_BBBB);
    @(negedge clk);
    cpu_req = 0;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'hC0DE_0000 | i;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    t_reset;
    t_hits_and_upgrade;
    t_write_miss;
    t_conflict;
    t_snoops;
    t_stall;
    fin = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!fin) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule